// File: doc/BRIEF.md
# Third Brake Light Mode Controller

This block drives the eight-lamp bar of a vehicle's centre high-mounted stop light. Three switch inputs ask for a left turn, a brake or a right turn. The block brings the switches into its clock domain and turns them into one operating mode. It then drives the bar with the animation for that mode. The bar is split into two halves of four lamps. The lower half (bits 3..0) is the left side and the upper half (bits 4..7) is the right side. A lamp is lit when its output bit is 0.

The operating mode is held in a small state machine with five states: `MODE_IDLE`, `MODE_LEFT`, `MODE_RIGHT`, `MODE_BRAKE` and `MODE_HAZARD`. Every clock, the next state is decoded from the synchronised switches, so each state can move straight to any other state.

The decode rules are:
- Left and right together go to `MODE_HAZARD`, whatever the brake switch says.
- Otherwise, brake goes to `MODE_BRAKE`.
- Otherwise, left alone goes to `MODE_LEFT` and right alone goes to `MODE_RIGHT`.
- No request goes to `MODE_IDLE`.

From the state, the block derives three active-low enables: left chase, brake animation and right chase. A chase sequencer turns the two chase enables into half-bar patterns. A brake generator turns the brake enable into a centre-out pattern that covers the full bar. The brake enable then picks between the two. When the state changes, the sequences restart, so the new pattern begins at its first step. The animation advances one step per clock.

Top module: `bl_third_light`

## Requirements
- R1: While `rst_n` is low, and after its release until a request reaches the mode register, `led_n_o` is 8'hFF (all lamps dark).
- R2: Lamps are active low (0 = lit). With no switch asserted, the state is `MODE_IDLE` and `led_n_o` is 8'hFF.
- R3: A switch change has no effect on the first two rising edges after it. The old pattern keeps running on those edges. The new mode takes effect on the third rising edge.
- R4: With right only, exactly one lamp of bits 7..4 is lit. It moves through bit 4, 5, 6, 7 and repeats, one step per clock. Bits 3..0 stay 1.
- R5: With left only, exactly one lamp of bits 3..0 is lit. It moves through bit 3, 2, 1, 0 and repeats, one step per clock. Bits 7..4 stay 1.
- R6: With brake alone, the bar repeats an 8-step cycle, one step per clock. The lit lamps in each step are, in order: {3,4}, {2..5}, {1..6}, {0..7}, {0,1,2,5,6,7}, {0,1,6,7}, {0,7}, none.
- R7: Brake together with exactly one turn switch shows only the R6 pattern. Changing which single turn switch accompanies the brake does not restart that pattern.
- R8: Left and right together, with or without brake, select `MODE_HAZARD`. In step k (k = 0..3, repeating) lamps 3-k and 4+k are lit and no other lamp is lit.
- R9: On every change of state, the new mode's pattern starts at its first step, on the edge where the state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; patterns advance one step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| turn_left_i | input | 1 | Left turn request switch, active high, asynchronous |
| brake_i | input | 1 | Brake request switch, active high, asynchronous |
| turn_right_i | input | 1 | Right turn request switch, active high, asynchronous |
| led_n_o | output | 8 | Lamp bar, active low; bits 3..0 left half, bits 7..4 right half |

## Verification
The bench runs each single request on its own: idle, left, right and brake. This shows that each chase has the right direction and half, and that the brake cycle has the right order.

It then applies brake with one turn, and swaps that turn between left and right while brake stays on. This separates a correct priority from a design that lets the turn through, and shows that the brake pattern does not restart when the state stays the same.

Left plus right is applied both with and without brake. This proves that the hazard mode overrides brake and that its two chases move in lockstep.

Short switches between modes mark the two edges of synchroniser delay and the restart at step zero on the third edge.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
package bl_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_LEFT   = 3'd1,
        MODE_RIGHT  = 3'd2,
        MODE_BRAKE  = 3'd3,
        MODE_HAZARD = 3'd4
    } mode_e;
endpackage

// File: rtl/bl_sync.sv
`timescale 1ns/1ps
module bl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bl_turn_seq.sv
`timescale 1ns/1ps
module bl_turn_seq #(
    parameter int HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_en_n,
    input  logic              right_en_n,
    input  logic              restart,
    output logic [2*HALF-1:0] led_n_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] step_q;
    logic          active;

    assign active = !left_en_n || !right_en_n;

    // one shared counter keeps both halves in lockstep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   step_q <= '0;
        else if (restart || !active)  step_q <= '0;
        else if (step_q == LAST)      step_q <= '0;
        else                          step_q <= step_q + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_lamp
            assign led_n_o[HALF+g]   = !(!right_en_n && (step_q == CW'(g)));
            assign led_n_o[HALF-1-g] = !(!left_en_n  && (step_q == CW'(g)));
        end
    endgenerate

    // R4
    right_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_en_n |-> $countones(~led_n_o[2*HALF-1:HALF]) == 1);
    // R5
    left_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_en_n |-> $countones(~led_n_o[HALF-1:0]) == 1);
    // R9
    turn_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> step_q == '0);
endmodule

// File: rtl/bl_brake_gen.sv
`timescale 1ns/1ps
module bl_brake_gen #(
    parameter int HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              restart,
    output logic [2*HALF-1:0] led_n_o
);
    localparam logic [HALF-1:0] FIRST = HALF'(1);

    logic [HALF-1:0] john_q;

    // twisted-ring counter: 2*HALF states, bit i widens the lit band by one lamp each side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               john_q <= FIRST;
        else if (restart || en_n) john_q <= FIRST;
        else                      john_q <= {john_q[HALF-2:0], ~john_q[HALF-1]};
    end

    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_band
            assign led_n_o[HALF+g]   = en_n | ~john_q[g];
            assign led_n_o[HALF-1-g] = en_n | ~john_q[g];
        end
    endgenerate

    // R6
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !restart) |=> $countones(john_q ^ $past(john_q)) == 1);
    // R6
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |-> $countones(~led_n_o[2*HALF-1:HALF]) == $countones(~led_n_o[HALF-1:0]));
endmodule

// File: rtl/bl_third_light.sv
`timescale 1ns/1ps
module bl_third_light #(
    parameter int HALF        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              turn_left_i,
    input  logic              brake_i,
    input  logic              turn_right_i,
    output logic [2*HALF-1:0] led_n_o
);
    import bl_pkg::*;

    localparam int NREQ = 3;

    logic [NREQ-1:0]   req_sync;
    logic              req_l, req_b, req_r;
    mode_e             state_q, state_d;
    logic              restart;
    logic              en_left_n, en_brake_n, en_right_n;
    logic [2*HALF-1:0] turn_led_n, brake_led_n;

    bl_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({turn_left_i, brake_i, turn_right_i}),
        .q_o   (req_sync)
    );

    assign {req_l, req_b, req_r} = req_sync;

    // next state: hazard > brake > single turn > idle
    always_comb begin
        unique case ({req_l, req_b, req_r})
            3'b000:  state_d = MODE_IDLE;
            3'b001:  state_d = MODE_RIGHT;
            3'b100:  state_d = MODE_LEFT;
            3'b010:  state_d = MODE_BRAKE;
            3'b011:  state_d = MODE_BRAKE;
            3'b110:  state_d = MODE_BRAKE;
            3'b101:  state_d = MODE_HAZARD;
            3'b111:  state_d = MODE_HAZARD;
            default: state_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_d;
    end

    assign restart = (state_d != state_q);

    // active-low mode enables
    always_comb begin
        en_left_n  = 1'b1;
        en_brake_n = 1'b1;
        en_right_n = 1'b1;
        unique case (state_q)
            MODE_IDLE:   ;
            MODE_LEFT:   en_left_n  = 1'b0;
            MODE_RIGHT:  en_right_n = 1'b0;
            MODE_BRAKE:  en_brake_n = 1'b0;
            MODE_HAZARD: begin
                en_left_n  = 1'b0;
                en_right_n = 1'b0;
            end
            default:     ;
        endcase
    end

    bl_turn_seq #(.HALF(HALF)) u_turn (
        .clk        (clk),
        .rst_n      (rst_n),
        .left_en_n  (en_left_n),
        .right_en_n (en_right_n),
        .restart    (restart),
        .led_n_o    (turn_led_n)
    );

    bl_brake_gen #(.HALF(HALF)) u_brake (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n    (en_brake_n),
        .restart (restart),
        .led_n_o (brake_led_n)
    );

    assign led_n_o = en_brake_n ? turn_led_n : brake_led_n;

    // R7
    brake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_brake_n |-> (en_left_n && en_right_n));
    // R7
    brake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b && !(req_l && req_r)) |=> state_q == MODE_BRAKE);
    // R8
    hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_l && req_r) |=> (state_q == MODE_HAZARD));
    // R2
    idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_IDLE) |-> (&led_n_o));
endmodule

// File: tb/test_bl_third_light.sv
`timescale 1ns/1ps
module test_bl_third_light;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tl = 1'b0, br = 1'b0, tr = 1'b0;
    logic [7:0] led;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    // bench model state (modes: 0 idle, 1 left, 2 right, 3 brake, 4 hazard)
    int h1 = 0, h2 = 0, prev_mode = 0, step = 0, lat = 100;
    logic pl = 1'b0, pb = 1'b0, pr = 1'b0;

    always #10 clk = ~clk;

    bl_third_light i_bl_third_light (
        .clk          (clk),
        .rst_n        (rst_n),
        .turn_left_i  (tl),
        .brake_i      (br),
        .turn_right_i (tr),
        .led_n_o      (led)
    );

    function automatic int decode(input logic l, input logic b, input logic r);
        if (l && r) return 4;
        if (b)      return 3;
        if (l)      return 1;
        if (r)      return 2;
        return 0;
    endfunction

    function automatic logic [7:0] pattern(input int mode, input int s);
        logic [7:0] v = 8'hFF;
        int k;
        int d;
        k = s % 4;
        if (mode == 1 || mode == 4) v[3-k] = 1'b0;
        if (mode == 2 || mode == 4) v[4+k] = 1'b0;
        if (mode == 3) begin
            k = s % 8;
            for (int b = 0; b < 8; b++) begin
                d = (b < 4) ? (3 - b) : (b - 4);
                if (k < 4) v[b] = !(d <= k);
                else       v[b] = !(d > k - 4);
            end
        end
        return v;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: led_n_o=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic b, input logic r, input int n, input string tag);
        int nm;
        string t;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tl = l; br = b; tr = r;
            if ({l, b, r} != {pl, pb, pr}) lat = 0;
            {pl, pb, pr} = {l, b, r};
            @(posedge clk);
            #1;
            nm = h2;
            h2 = h1;
            h1 = decode(l, b, r);
            if (nm != prev_mode) step = 0;
            else                 step++;
            lat++;
            t = tag;
            if (lat < 3)                          t = "R3";
            else if (lat == 3 && nm != prev_mode) t = "R9";
            prev_mode = nm;
            exp_q.push_back(pattern(nm, step));
            tag_q.push_back(t);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                check(led, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: dark during reset, even with requests present
        tl = 1'b1; br = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(led, 8'hFF, "R1");
        end
        tl = 1'b0; br = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 3, "R1");
        drive(0, 0, 0, 4, "R2");
        drive(0, 0, 1, 12, "R4");
        drive(1, 0, 0, 12, "R5");
        drive(0, 1, 0, 20, "R6");
        drive(0, 0, 0, 5, "R2");
        drive(0, 1, 1, 10, "R7");
        drive(1, 1, 0, 10, "R7");
        drive(1, 0, 1, 12, "R8");
        drive(1, 1, 1, 12, "R8");
        drive(0, 0, 1, 5, "R4");
        drive(1, 0, 0, 4, "R9");
        drive(0, 0, 1, 2, "R3");
        drive(1, 1, 1, 6, "R8");
        drive(0, 0, 0, 6, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule